// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 14-bit successive-approximation converter. A rising edge on the convert-start input puts the analog front end into hold. The same edge samples a level that picks the conversion clock source for that conversion. The block then walks the trial code from the most significant bit down, one decision per conversion-clock tick, using a single comparator bit. On the fifteenth tick it moves the finished code into an output register. On the sixteenth tick it ends the conversion and returns the front end to track.

The analog parts are not in this block: the track/hold, the trial DAC, the comparator and the on-chip oscillator. Each conversion-clock source is modelled as a one-cycle enable on the system clock. The comparator is modelled as one input bit that reports whether the held input lies below the current trial level.

A status output works in one of two modes, chosen by the convert-start level when a conversion ends. In one mode it is a busy level. In the other it is a one-clock end-of-conversion dip. Results are read through a chip-select/read gated data path. A standby input stops all conversion activity, but the stored result can still be read.

Top module: `sar_conv_seq`

## Requirements
- R1: When idle and out of standby, a rising edge on `conv_start` is acted on at the clock edge that samples it. At that edge `hold` and `status` go to 1 and `dac_trial` becomes 14'h2000 (only the top bit set).
- R2: The level of `clk_pin` at the start edge sets `clk_sel_ext` for the whole conversion (1 = `ext_tick`, 0 = `int_tick`). Pulses on the unselected tick input have no effect.
- R3: A conversion lasts exactly 16 selected ticks. `hold` and `status` stay 1 through tick 15, and `hold` returns to 0 at tick 16.
- R4: Decisions run from the top bit down, one per tick over ticks 1 to 14. A tried bit is cleared when `cmp_below` is 1 at its tick. After tick 14, `dac_trial` equals the code of the held input.
- R5: The output register loads at tick 15 and at no other time. After tick 14 the bus still shows the previous result.
- R6: If `conv_start` is 1 at tick 16, `status` is 0 for exactly one clock and then returns to 1.
- R7: If `conv_start` is 0 at tick 16, `status` goes to 0 and stays 0 until the next accepted start edge.
- R8: `dout_oe` is 1 only when `cs_n` and `rd_n` are both 0. Otherwise `dout` reads 0. `cs_n` may stay low permanently.
- R9: With `BIPOLAR`=1 the stored word is the raw code with its top bit inverted (raw 14'h1FFF reads 14'h3FFF, raw 14'h2000 reads 14'h0000). With `BIPOLAR`=0 the raw code is stored unchanged.
- R10: A rising edge on `conv_start` during a conversion is ignored. Timing and result are unchanged.
- R11: `stby_n`=0 abandons any conversion, forcing `hold` and `status` to 0, and start edges are ignored while it is 0. The stored result is kept and stays readable. When standby is released while `conv_start` is already high, no conversion starts.
- R12: After reset `hold`, `status` and `clk_sel_ext` are 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Convert-start level; rising edge starts a conversion |
| clk_pin | input | 1 | Clock-source level sampled at the start edge |
| int_tick | input | 1 | Internal conversion-clock enable |
| ext_tick | input | 1 | External conversion-clock enable |
| stby_n | input | 1 | Active-low standby |
| cmp_below | input | 1 | Comparator: held input below trial level |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| hold | output | 1 | 1 = track/hold in hold |
| clk_sel_ext | output | 1 | Latched clock-source select |
| dac_trial | output | 14 | Current trial code to the DAC |
| status | output | 1 | Busy / end-of-conversion status |
| dout | output | 14 | Read data, 0 when not enabled |
| dout_oe | output | 1 | Data output enable |

## Verification
The start response is due at the clock edge that first samples `conv_start` high. The trial code, load and end each follow the tick edge that completes that tick number. The end-of-conversion dip lasts one edge after tick 16. The bench drives every input just after a falling edge and checks just before the next one, so each check sees exactly one register update. Between two selected ticks it inserts a cycle with only the unselected tick active. An early end caused by counting the wrong source therefore shows up at the status check of the next tick.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // status line states
  typedef enum logic [1:0] {
    STS_LOW  = 2'd0,   // idle, low (busy mode or standby)
    STS_BUSY = 2'd1,   // converting
    STS_EOC  = 2'd2,   // one-clock end-of-conversion dip
    STS_HIGH = 2'd3    // idle, high (end-of-conversion mode)
  } sts_e;

endpackage

// File: rtl/sar_trigger.sv
module sar_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  input  logic clk_pin,
  input  logic stby_n,
  input  logic busy,
  output logic start_go,
  output logic sel_ext
);

  logic prev_q, prev_n;
  logic sel_q, sel_n;

  always_comb begin
    start_go = conv_start & ~prev_q & stby_n & ~busy;
    prev_n   = conv_start;
    sel_n    = start_go ? clk_pin : sel_q;
  end

  // previous level resets high so a level already high at reset is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      sel_q  <= 1'b0;
    end else begin
      prev_q <= prev_n;
      sel_q  <= sel_n;
    end
  end

  assign sel_ext = sel_q;

  AST_SEL_STABLE_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_ext)); // R2

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int N_BITS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic              sel_ext,
  input  logic              int_tick,
  input  logic              ext_tick,
  input  logic              cmp_below,
  input  logic              stby_n,
  output logic              busy,
  output logic              hold,
  output logic [N_BITS-1:0] trial,
  output logic              load,
  output logic              done
);

  localparam int LATCH_TICK = N_BITS + 1;
  localparam int END_TICK   = N_BITS + 2;
  localparam int CNT_W      = $clog2(END_TICK + 1);
  localparam logic [N_BITS-1:0] TOP_BIT = {1'b1, {(N_BITS-1){1'b0}}};

  logic              run_q, run_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [N_BITS-1:0] code_q, code_n;
  logic [N_BITS-1:0] mask_q, mask_n;
  logic              tick;
  logic              step;

  always_comb begin
    tick = sel_ext ? ext_tick : int_tick;
    step = run_q & tick & stby_n;
    load = step & (cnt_q == CNT_W'(LATCH_TICK - 1));
    done = step & (cnt_q == CNT_W'(END_TICK - 1));
  end

  always_comb begin
    run_n  = run_q;
    cnt_n  = cnt_q;
    code_n = code_q;
    mask_n = mask_q;
    if (!stby_n) begin
      run_n = 1'b0;
    end else if (start_go) begin
      run_n  = 1'b1;
      cnt_n  = '0;
      code_n = TOP_BIT;
      mask_n = TOP_BIT;
    end else if (step) begin
      cnt_n = cnt_q + 1'b1;
      if (mask_q != '0) begin
        code_n = (cmp_below ? (code_q & ~mask_q) : code_q) | (mask_q >> 1);
        mask_n = mask_q >> 1;
      end
      if (done) begin
        run_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      code_q <= '0;
      mask_q <= '0;
    end else begin
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      code_q <= code_n;
      mask_q <= mask_n;
    end
  end

  assign busy  = run_q;
  assign hold  = run_q;
  assign trial = code_q;

  AST_START_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> hold); // R1
  AST_TICK_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < CNT_W'(END_TICK))); // R3
  AST_END_RELEASES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !hold); // R3
  AST_DECISIONS_DONE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (mask_q == '0)); // R4

endmodule

// File: rtl/sar_status.sv
module sar_status
  import sar_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic done,
  input  logic conv_start,
  input  logic stby_n,
  output logic status
);

  sts_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (!stby_n) begin
      st_n = STS_LOW;
    end else if (start_go) begin
      st_n = STS_BUSY;
    end else if (done) begin
      st_n = conv_start ? STS_EOC : STS_LOW;
    end else if (st_q == STS_EOC) begin
      st_n = STS_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= STS_LOW;
    end else begin
      st_q <= st_n;
    end
  end

  assign status = (st_q == STS_BUSY) || (st_q == STS_HIGH);

  AST_EOC_DIP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == STS_EOC && stby_n) |=> status); // R6
  AST_BUSY_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == STS_LOW && !start_go) |=> !status); // R7

endmodule

// File: rtl/sar_outreg.sv
module sar_outreg #(
  parameter int N_BITS  = 14,
  parameter bit BIPOLAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [N_BITS-1:0] result,
  input  logic              cs_n,
  input  logic              rd_n,
  output logic [N_BITS-1:0] dout,
  output logic              dout_oe
);

  logic [N_BITS-1:0] coded;
  logic [N_BITS-1:0] word_q, word_n;

  generate
    if (BIPOLAR) begin : g_twos
      assign coded = {~result[N_BITS-1], result[N_BITS-2:0]};
    end else begin : g_straight
      assign coded = result;
    end
  endgenerate

  always_comb begin
    word_n  = load ? coded : word_q;
    dout_oe = ~cs_n & ~rd_n;
    dout    = dout_oe ? word_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_n;
    end
  end

  AST_WORD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_q)); // R5

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int N_BITS  = 14,
  parameter bit BIPOLAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              clk_pin,
  input  logic              int_tick,
  input  logic              ext_tick,
  input  logic              stby_n,
  input  logic              cmp_below,
  input  logic              cs_n,
  input  logic              rd_n,
  output logic              hold,
  output logic              clk_sel_ext,
  output logic [N_BITS-1:0] dac_trial,
  output logic              status,
  output logic [N_BITS-1:0] dout,
  output logic              dout_oe
);

  logic start_go;
  logic busy;
  logic load;
  logic done;

  sar_trigger u_trigger (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .clk_pin    (clk_pin),
    .stby_n     (stby_n),
    .busy       (busy),
    .start_go   (start_go),
    .sel_ext    (clk_sel_ext)
  );

  sar_engine #(.N_BITS(N_BITS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_go  (start_go),
    .sel_ext   (clk_sel_ext),
    .int_tick  (int_tick),
    .ext_tick  (ext_tick),
    .cmp_below (cmp_below),
    .stby_n    (stby_n),
    .busy      (busy),
    .hold      (hold),
    .trial     (dac_trial),
    .load      (load),
    .done      (done)
  );

  sar_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_go   (start_go),
    .done       (done),
    .conv_start (conv_start),
    .stby_n     (stby_n),
    .status     (status)
  );

  sar_outreg #(.N_BITS(N_BITS), .BIPOLAR(BIPOLAR)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .result  (dac_trial),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

  AST_STANDBY_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> (!hold && !status)); // R11

endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

  logic clk = 1'b0;
  logic rst_n;
  logic conv_start, clk_pin, int_tick, ext_tick, stby_n, cs_n, rd_n;
  logic [13:0] analog;
  logic hold_b, sel_b, status_b, oe_b;
  logic [13:0] trial_b, dout_b;
  logic hold_u, sel_u, status_u, oe_u;
  logic [13:0] trial_u, dout_u;
  logic cmp_b, cmp_u;

  int n_tests = 0;
  int n_fail  = 0;
  logic [13:0] prev_b = 14'h0;
  logic [13:0] prev_u = 14'h0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // analog model: held input below trial level
  assign cmp_b = (analog < trial_b);
  assign cmp_u = (analog < trial_u);

  sar_conv_seq #(.N_BITS(14), .BIPOLAR(1'b1)) i_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .clk_pin(clk_pin),
    .int_tick(int_tick), .ext_tick(ext_tick), .stby_n(stby_n),
    .cmp_below(cmp_b), .cs_n(cs_n), .rd_n(rd_n), .hold(hold_b),
    .clk_sel_ext(sel_b), .dac_trial(trial_b), .status(status_b),
    .dout(dout_b), .dout_oe(oe_b)
  );

  sar_conv_seq #(.N_BITS(14), .BIPOLAR(1'b0)) i_sar_conv_seq_uni (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .clk_pin(clk_pin),
    .int_tick(int_tick), .ext_tick(ext_tick), .stby_n(stby_n),
    .cmp_below(cmp_u), .cs_n(cs_n), .rd_n(rd_n), .hold(hold_u),
    .clk_sel_ext(sel_u), .dac_trial(trial_u), .status(status_u),
    .dout(dout_u), .dout_oe(oe_u)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_tick(input bit ext);
    if (ext) ext_tick = 1'b1; else int_tick = 1'b1;
    cyc();
    ext_tick = 1'b0;
    int_tick = 1'b0;
  endtask

  task automatic do_conv(input logic [13:0] a, input bit ext, input bit eoc_mode, input bit glitch);
    logic [13:0] exp_b;
    exp_b = a ^ 14'h2000;
    analog = a;
    clk_pin = ext;
    conv_start = 1'b0;
    cyc();
    conv_start = 1'b1;
    cyc();
    chk("R1 status at start", status_b, 1);
    chk("R1 hold at start", hold_b, 1);
    chk("R1 first trial", trial_b, 14'h2000);
    chk("R2 source latched", sel_b, ext);
    clk_pin = ~ext;
    for (int k = 1; k <= 16; k++) begin
      pulse_tick(~ext);
      chk("R2 unselected tick ignored", {hold_b, status_b}, 2'b11);
      pulse_tick(ext);
      if (glitch && k == 6) begin
        conv_start = 1'b0;
        cyc();
        conv_start = 1'b1;
        cyc();
        chk("R10 restart ignored", hold_b, 1);
      end
      if (!eoc_mode && k == 4) conv_start = 1'b0;
      if (k == 14) begin
        chk("R4 final trial code", trial_b, a);
        chk("R5 old word before tick 15", dout_b, prev_b);
        chk("R5 old word before tick 15 uni", dout_u, prev_u);
      end
      if (k == 15) begin
        chk("R9 bipolar word", dout_b, exp_b);
        chk("R9 straight word", dout_u, a);
        chk("R3 still busy at tick 15", {hold_b, status_b}, 2'b11);
      end
      if (k == 16) begin
        chk("R3 hold released", hold_b, 0);
        if (eoc_mode) chk("R6 dip low", status_b, 0);
        else          chk("R7 busy low", status_b, 0);
      end
    end
    cyc();
    if (eoc_mode) chk("R6 back high", status_b, 1);
    else          chk("R7 stays low", status_b, 0);
    cyc();
    if (eoc_mode) chk("R6 stays high", status_b, 1);
    else          chk("R7 stays low later", status_b, 0);
    chk("R5 word kept", dout_b, exp_b);
    prev_b = exp_b;
    prev_u = a;
  endtask

  initial begin
    rst_n = 1'b0;
    conv_start = 1'b0; clk_pin = 1'b0; int_tick = 1'b0; ext_tick = 1'b0;
    stby_n = 1'b1; cs_n = 1'b0; rd_n = 1'b1; analog = 14'h0;
    repeat (3) cyc();
    chk("R12 reset status", status_b, 0);
    chk("R12 reset hold", hold_b, 0);
    chk("R12 reset select", sel_b, 0);
    rd_n = 1'b0; #1;
    chk("R12 reset word", dout_b, 14'h0);
    rst_n = 1'b1;
    cyc();
    // R8 bus gating
    prev_b = 14'h0;
    rd_n = 1'b1; #1;
    chk("R8 oe read high", oe_b, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk("R8 oe cs high", oe_b, 0);
    cs_n = 1'b0; #1;
    chk("R8 oe both low", oe_b, 1);

    // corners, then a strided sweep over the code space
    do_conv(14'h1FFF, 1'b0, 1'b1, 1'b0);
    chk("R9 midscale below reads all ones", dout_b, 14'h3FFF);
    do_conv(14'h2000, 1'b1, 1'b0, 1'b0);
    chk("R9 midscale reads zero", dout_b, 14'h0000);
    do_conv(14'h0000, 1'b0, 1'b0, 1'b0);
    do_conv(14'h3FFF, 1'b1, 1'b1, 1'b1);
    do_conv(14'h0001, 1'b1, 1'b1, 1'b0);
    do_conv(14'h3FFE, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 270; i++) begin
      do_conv(14'((i * 61 + 7) % 16384), i[0], i[1], i[1] && (i % 5 == 0));
    end

    // R8: word hidden when read is released, visible again on read
    rd_n = 1'b1; #1;
    chk("R8 dout zero when idle bus", dout_b, 14'h0);
    rd_n = 1'b0; #1;
    chk("R8 dout on read", dout_b, prev_b);

    // R11 standby aborts a conversion
    analog = 14'h1234; clk_pin = 1'b0;
    conv_start = 1'b0; cyc();
    conv_start = 1'b1; cyc();
    for (int k = 0; k < 5; k++) pulse_tick(1'b0);
    stby_n = 1'b0;
    cyc();
    chk("R11 hold dropped", hold_b, 0);
    chk("R11 status dropped", status_b, 0);
    chk("R11 word readable", dout_b, prev_b);
    conv_start = 1'b0; cyc();
    conv_start = 1'b1; cyc();
    chk("R11 start ignored in standby", {hold_b, status_b}, 2'b00);
    for (int k = 0; k < 20; k++) pulse_tick(1'b0);
    chk("R11 word unchanged", dout_b, prev_b);
    stby_n = 1'b1;
    cyc(); cyc();
    chk("R11 no start on release", {hold_b, status_b}, 2'b00);
    do_conv(14'h0ABC, 1'b0, 1'b0, 1'b0);
    chk("R11 conversion after standby", dout_u, 14'h0ABC);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule